// File: doc/BRIEF.md
# Endpoint DMA Slave Engine

This block links one endpoint buffer to an external fly-by DMA controller. It raises a request when the buffer can take part in a transfer and moves one item on each qualified data strobe. The item is one byte or one 16-bit word, fixed at elaboration. The endpoint's direction bit sets which way data moves: an OUT endpoint's buffer is read out to the DMA bus, and an IN endpoint's buffer is filled from it.

The strobe style can be chosen at run time. In strobe-qualified mode, an active acknowledge together with the read strobe (OUT) or write strobe (IN) makes one beat. In acknowledge-strobe mode, an active acknowledge alone makes a beat and both strobes are ignored. The request, acknowledge and end-of-transfer pins each have their own active level. Pacing is either single-cycle or burst: in single-cycle mode the request drops after every item, and in burst mode it drops only after a fixed burst.

A transfer starts on the rising edge of the enable input, which also loads a byte counter. It ends on one of four events: the external end-of-transfer pin, the counter running out, a short packet on an OUT endpoint, or the enable input being cleared. The engine then holds a done flag and a cause code. It raises a one-cycle interrupt pulse for every cause except disable. The request stays inactive until the enable input is cleared and set again.

Top module: `usb_ep_dma_engine`

## Requirements
- R1: After reset, no transfer is active: the request output is at its inactive level, and `xfer_done` and `xfer_irq` are 0.
- R2: `cfg_req_pol`, `cfg_ack_pol` and `cfg_eot_pol` set the active level of the request, acknowledge and end-of-transfer pins (1 = active high, 0 = active low).
- R3: With `cfg_ack_only`=0, a beat happens in a cycle where acknowledge is active and the strobe for the current direction is high (`dma_rd_stb` for OUT, `dma_wr_stb` for IN). The strobe of the other direction has no effect.
- R4: With `cfg_ack_only`=1, every cycle with acknowledge active is a beat, and `dma_rd_stb`/`dma_wr_stb` are ignored.
- R5: With `cfg_burst`=0, the request is inactive in the cycle after every beat.
- R6: With `cfg_burst`=1, the request stays active across beats and goes inactive for one cycle after each group of BURST_BYTES/BUS_BYTES beats.
- R7: A rising edge of `cfg_en` loads `cfg_count`. Each beat reduces the remaining count by BUS_BYTES. With `cfg_cnt_en`=1, the beat that brings the count to zero ends the transfer with cause 1 (01b) and an interrupt. The request then stays inactive until re-enable.
- R8: On an OUT endpoint (`cfg_dir_in`=0), an active end-of-transfer pin during a transfer pulses `buf_flush` in that same cycle. The transfer then ends with cause 0 (00b) and an interrupt.
- R9: On an IN endpoint (`cfg_dir_in`=1), an active end-of-transfer pin during a transfer pulses `buf_commit` in that same cycle. The transfer then ends with cause 0 and an interrupt.
- R10: With `cfg_short_en`=1 on an OUT endpoint, a beat that moves the last item of a short packet (`buf_rd_last`=1 and `buf_rd_short`=1) ends the transfer with cause 2 (10b) and an interrupt.
- R11: Clearing `cfg_en` during a transfer ends it with cause 3 (11b) and no interrupt.
- R12: On OUT, each beat pops one item and drives it on `dma_rdata` (0 in cycles with no beat). On IN, each beat pushes `dma_wdata` into the buffer. Pop and push never occur together.
- R13: Outside a transfer, strobes cause no pop or push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | DMA enable; rising edge starts a transfer |
| cfg_dir_in | input | 1 | Endpoint direction: 1 = IN (buffer written), 0 = OUT (buffer read) |
| cfg_ack_only | input | 1 | 1 = acknowledge is the data strobe |
| cfg_burst | input | 1 | 1 = burst pacing, 0 = single-cycle pacing |
| cfg_cnt_en | input | 1 | Counter termination enable |
| cfg_short_en | input | 1 | Short-packet termination enable |
| cfg_req_pol | input | 1 | Request active level |
| cfg_ack_pol | input | 1 | Acknowledge active level |
| cfg_eot_pol | input | 1 | End-of-transfer active level |
| cfg_count | input | CNT_W | Byte count loaded at enable |
| dma_req | output | 1 | DMA request pin |
| dma_ack | input | 1 | DMA acknowledge pin |
| dma_eot | input | 1 | End-of-transfer pin |
| dma_rd_stb | input | 1 | Read strobe, active high |
| dma_wr_stb | input | 1 | Write strobe, active high |
| dma_wdata | input | 8*BUS_BYTES | Data from DMA bus (IN) |
| dma_rdata | output | 8*BUS_BYTES | Data to DMA bus (OUT) |
| buf_rd_valid | input | 1 | OUT buffer holds an item |
| buf_rd_data | input | 8*BUS_BYTES | OUT buffer head item |
| buf_rd_last | input | 1 | Head item is the last of its packet |
| buf_rd_short | input | 1 | Current packet is short |
| buf_rd_pop | output | 1 | Remove head item |
| buf_wr_ready | input | 1 | IN buffer has room |
| buf_wr_data | output | 8*BUS_BYTES | Item to IN buffer |
| buf_wr_push | output | 1 | Write item to IN buffer |
| buf_flush | output | 1 | Discard the active OUT buffer half |
| buf_commit | output | 1 | Mark the partial IN buffer ready to send |
| xfer_done | output | 1 | Transfer ended |
| xfer_cause | output | 2 | End cause: 0 pin, 1 count, 2 short, 3 disable |
| xfer_irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bound assertions check, on every cycle, these rules: pop and push never occur together; no beat and no request appear while the done flag is set; every single-cycle beat is followed by an inactive request; every flush leads to a pin-caused end; and no interrupt carries the disable cause. Whether a given strobe combination counts as a beat, how many beats a burst allows, and which beat exhausts the counter or closes a short packet all depend on the configuration and on data history. Only the bench's scenarios, checked against its cycle-by-cycle reference model, can show these.

// File: rtl/usb_dma_pkg.sv
package usb_dma_pkg;
   typedef enum logic [1:0] {
      CAUSE_PIN   = 2'd0,
      CAUSE_COUNT = 2'd1,
      CAUSE_SHORT = 2'd2,
      CAUSE_OFF   = 2'd3
   } eot_cause_e;
endpackage

// File: rtl/dma_pin_levels.sv
module dma_pin_levels (
   input  logic cfg_req_pol,
   input  logic cfg_ack_pol,
   input  logic cfg_eot_pol,
   input  logic ack_pin,
   input  logic eot_pin,
   input  logic req_int,
   output logic ack_int,
   output logic eot_int,
   output logic req_pin
);
   // every pin is normalised to active-high inside the engine
   assign ack_int = (ack_pin == cfg_ack_pol);
   assign eot_int = (eot_pin == cfg_eot_pol);
   assign req_pin = cfg_req_pol ? req_int : ~req_int;
endmodule

// File: rtl/dma_beat_pacer.sv
module dma_beat_pacer #(
   parameter int ITEMS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic beat,
   input  logic burst_mode,
   output logic gap
);
   logic gap_q;

   generate
      if (ITEMS == 1) begin : g_one
         logic unused_mode;
         assign unused_mode = burst_mode;
         always_ff @(posedge clk) begin
            if (!rst_n || restart) gap_q <= 1'b0;
            else                   gap_q <= beat;
         end
      end else begin : g_many
         localparam int IW = $clog2(ITEMS);
         logic [IW-1:0] n_q;
         logic          last;
         assign last = !burst_mode || (n_q == IW'(ITEMS - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
               gap_q <= 1'b0;
               n_q   <= '0;
            end else begin
               gap_q <= beat && last;
               if (beat) n_q <= last ? '0 : n_q + 1'b1;
            end
         end
      end
   endgenerate

   assign gap = gap_q;
endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl
   import usb_dma_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int STEP  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic             cfg_cnt_en,
   input  logic             cfg_short_en,
   input  logic             dir_in,
   input  logic             beat,
   input  logic             eot_hit,
   input  logic             short_hit,
   output logic             run,
   output logic             restart,
   output logic             done,
   output eot_cause_e       cause,
   output logic             irq
);
   localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

   logic             en_q, active_q, done_q, irq_q;
   logic [CNT_W-1:0] cnt_q;
   eot_cause_e       cause_q, cause_n;
   logic             cnt_end, short_end, term;

   assign restart   = cfg_en && !en_q;
   assign run       = active_q && cfg_en;
   assign cnt_end   = beat && cfg_cnt_en && (cnt_q <= STEP_V);
   assign short_end = beat && cfg_short_en && !dir_in && short_hit;
   assign term      = run && (eot_hit || cnt_end || short_end);

   always_comb begin
      if (eot_hit)      cause_n = CAUSE_PIN;
      else if (cnt_end) cause_n = CAUSE_COUNT;
      else              cause_n = CAUSE_SHORT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         active_q <= 1'b0;
         done_q   <= 1'b0;
         irq_q    <= 1'b0;
         cnt_q    <= '0;
         cause_q  <= CAUSE_PIN;
      end else begin
         en_q <= cfg_en;
         if (restart) begin
            active_q <= 1'b1;
            done_q   <= 1'b0;
            irq_q    <= 1'b0;
            cnt_q    <= cfg_count;
         end else if (active_q && !cfg_en) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
            irq_q    <= 1'b0;
            cause_q  <= CAUSE_OFF;
         end else if (term) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
            irq_q    <= 1'b1;
            cause_q  <= cause_n;
         end else begin
            irq_q <= 1'b0;
            if (run && beat) cnt_q <= (cnt_q >= STEP_V) ? cnt_q - STEP_V : '0;
         end
      end
   end

   assign done  = done_q;
   assign cause = cause_q;
   assign irq   = irq_q;
endmodule

// File: rtl/usb_ep_dma_engine.sv
module usb_ep_dma_engine
   import usb_dma_pkg::*;
#(
   parameter int BUS_BYTES   = 2,
   parameter int BURST_BYTES = 16,
   parameter int CNT_W       = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_en,
   input  logic                   cfg_dir_in,
   input  logic                   cfg_ack_only,
   input  logic                   cfg_burst,
   input  logic                   cfg_cnt_en,
   input  logic                   cfg_short_en,
   input  logic                   cfg_req_pol,
   input  logic                   cfg_ack_pol,
   input  logic                   cfg_eot_pol,
   input  logic [CNT_W-1:0]       cfg_count,
   output logic                   dma_req,
   input  logic                   dma_ack,
   input  logic                   dma_eot,
   input  logic                   dma_rd_stb,
   input  logic                   dma_wr_stb,
   input  logic [8*BUS_BYTES-1:0] dma_wdata,
   output logic [8*BUS_BYTES-1:0] dma_rdata,
   input  logic                   buf_rd_valid,
   input  logic [8*BUS_BYTES-1:0] buf_rd_data,
   input  logic                   buf_rd_last,
   input  logic                   buf_rd_short,
   output logic                   buf_rd_pop,
   input  logic                   buf_wr_ready,
   output logic [8*BUS_BYTES-1:0] buf_wr_data,
   output logic                   buf_wr_push,
   output logic                   buf_flush,
   output logic                   buf_commit,
   output logic                   xfer_done,
   output logic [1:0]             xfer_cause,
   output logic                   xfer_irq
);
   localparam int ITEMS = BURST_BYTES / BUS_BYTES;
   localparam int DW    = 8 * BUS_BYTES;

   generate
      if (BUS_BYTES != 1 && BUS_BYTES != 2) begin : g_bad_width
         $error("BUS_BYTES must be 1 or 2");
      end
      if (BURST_BYTES > 16 || BURST_BYTES < BUS_BYTES || (BURST_BYTES % BUS_BYTES) != 0) begin : g_bad_burst
         $error("BURST_BYTES must be a multiple of BUS_BYTES, at most 16");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W too small");
      end
   endgenerate

   logic       ack_i, eot_i, req_i, strobe, avail, beat, gap, run, restart;
   eot_cause_e cause;

   dma_pin_levels u_pins (
      .cfg_req_pol (cfg_req_pol),
      .cfg_ack_pol (cfg_ack_pol),
      .cfg_eot_pol (cfg_eot_pol),
      .ack_pin     (dma_ack),
      .eot_pin     (dma_eot),
      .req_int     (req_i),
      .ack_int     (ack_i),
      .eot_int     (eot_i),
      .req_pin     (dma_req)
   );

   // beat qualification: acknowledge alone, or acknowledge plus direction strobe
   assign strobe = cfg_ack_only ? ack_i
                                : ack_i && (cfg_dir_in ? dma_wr_stb : dma_rd_stb);
   assign avail  = cfg_dir_in ? buf_wr_ready : buf_rd_valid;
   assign beat   = run && strobe && avail;
   assign req_i  = run && avail && !gap;

   dma_beat_pacer #(.ITEMS(ITEMS)) u_pacer (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .beat       (beat),
      .burst_mode (cfg_burst),
      .gap        (gap)
   );

   dma_xfer_ctl #(.CNT_W(CNT_W), .STEP(BUS_BYTES)) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_en       (cfg_en),
      .cfg_count    (cfg_count),
      .cfg_cnt_en   (cfg_cnt_en),
      .cfg_short_en (cfg_short_en),
      .dir_in       (cfg_dir_in),
      .beat         (beat),
      .eot_hit      (eot_i),
      .short_hit    (buf_rd_last && buf_rd_short),
      .run          (run),
      .restart      (restart),
      .done         (xfer_done),
      .cause        (cause),
      .irq          (xfer_irq)
   );

   assign buf_rd_pop  = beat && !cfg_dir_in;
   assign buf_wr_push = beat && cfg_dir_in;
   assign dma_rdata   = buf_rd_pop ? buf_rd_data : DW'(0);
   assign buf_wr_data = dma_wdata;
   assign buf_flush   = run && eot_i && !cfg_dir_in;
   assign buf_commit  = run && eot_i && cfg_dir_in;
   assign xfer_cause  = cause;
endmodule

// File: rtl/usb_dma_chk.sv
module usb_dma_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_burst,
   input logic       cfg_req_pol,
   input logic       dma_req,
   input logic       buf_rd_pop,
   input logic       buf_wr_push,
   input logic       buf_flush,
   input logic       xfer_done,
   input logic [1:0] xfer_cause,
   input logic       xfer_irq
);
   p_no_pop_push_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(buf_rd_pop && buf_wr_push));

   p_done_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (dma_req != cfg_req_pol));

   p_done_no_beat_r13: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> !(buf_rd_pop || buf_wr_push));

   p_single_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_burst && (buf_rd_pop || buf_wr_push)) |=> (dma_req != cfg_req_pol));

   p_flush_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_flush |=> (xfer_done && xfer_cause == 2'd0));

   p_irq_not_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_irq |-> (xfer_cause != 2'd3));
endmodule

bind usb_ep_dma_engine usb_dma_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_burst   (cfg_burst),
   .cfg_req_pol (cfg_req_pol),
   .dma_req     (dma_req),
   .buf_rd_pop  (buf_rd_pop),
   .buf_wr_push (buf_wr_push),
   .buf_flush   (buf_flush),
   .xfer_done   (xfer_done),
   .xfer_cause  (xfer_cause),
   .xfer_irq    (xfer_irq)
);

// File: tb/sim_usb_ep_dma_engine.sv
`timescale 1ns/1ps
module sim_usb_ep_dma_engine;
   localparam int BB    = 2;
   localparam int BURST = 16;
   localparam int ITEMS = BURST / BB;
   localparam int DW    = 8 * BB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic cfg_en = 0, cfg_dir_in = 0, cfg_ack_only = 0, cfg_burst = 0;
   logic cfg_cnt_en = 0, cfg_short_en = 0;
   logic cfg_req_pol = 1, cfg_ack_pol = 1, cfg_eot_pol = 1;
   logic [15:0] cfg_count = 0;
   logic dma_ack = 0, dma_eot = 0, dma_rd_stb = 0, dma_wr_stb = 0;
   logic [DW-1:0] dma_wdata = 0;
   logic buf_rd_valid = 1, buf_wr_ready = 1, short_on = 0;
   int   last_idx = -1;
   int   rd_ptr = 0;
   logic [DW-1:0] buf_rd_data;
   logic buf_rd_last, buf_rd_short;
   logic dma_req, buf_rd_pop, buf_wr_push, buf_flush, buf_commit;
   logic xfer_done, xfer_irq;
   logic [1:0] xfer_cause;
   logic [DW-1:0] dma_rdata, buf_wr_data;

   assign buf_rd_data  = {rd_ptr[6:0], 1'b1, rd_ptr[6:0], 1'b0};
   assign buf_rd_last  = short_on && (rd_ptr == last_idx);
   assign buf_rd_short = short_on;

   usb_ep_dma_engine #(.BUS_BYTES(BB), .BURST_BYTES(BURST), .CNT_W(16)) u0 (.*);

   int total = 0, bad = 0;
   logic finished = 0;
   logic [DW-1:0] pushed [$];

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // bench-side buffer
   always @(posedge clk) begin
      if (buf_rd_pop) rd_ptr <= rd_ptr + 1;
      if (buf_wr_push) pushed.push_back(buf_wr_data);
   end

   // reference model, compared every cycle at the falling edge
   logic m_active = 0, m_en_q = 0, m_gap = 0, m_done = 0, m_irq = 0;
   int   m_bcnt = 0, m_cnt = 0, m_cause = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         m_active = 0; m_en_q = 0; m_gap = 0; m_done = 0; m_irq = 0;
         m_bcnt = 0; m_cnt = 0; m_cause = 0;
      end else begin : model
         logic ack_i, eot_i, run, avail, stb, beat, req_i, term, rise, lastb;
         int cause_n;
         ack_i = (dma_ack == cfg_ack_pol);
         eot_i = (dma_eot == cfg_eot_pol);
         run   = m_active && cfg_en;
         avail = cfg_dir_in ? buf_wr_ready : buf_rd_valid;
         stb   = cfg_ack_only ? ack_i : (ack_i && (cfg_dir_in ? dma_wr_stb : dma_rd_stb));
         beat  = run && stb && avail;
         req_i = run && avail && !m_gap;
         chk("R2 R5 R6 request", dma_req, cfg_req_pol ? req_i : !req_i);
         chk("R3 R4 R12 pop", buf_rd_pop, beat && !cfg_dir_in);
         chk("R3 R4 R12 push", buf_wr_push, beat && cfg_dir_in);
         chk("R12 rdata", dma_rdata, (beat && !cfg_dir_in) ? buf_rd_data : 0);
         chk("R12 wdata", buf_wr_data, dma_wdata);
         chk("R8 flush", buf_flush, run && eot_i && !cfg_dir_in);
         chk("R9 commit", buf_commit, run && eot_i && cfg_dir_in);
         chk("R7 done", xfer_done, m_done);
         chk("R7 cause", xfer_cause, m_cause);
         chk("R11 irq", xfer_irq, m_irq);
         // next state
         rise  = cfg_en && !m_en_q;
         lastb = !cfg_burst || (m_bcnt == ITEMS - 1);
         cause_n = -1;
         if (run) begin
            if (eot_i) cause_n = 0;
            else if (beat && cfg_cnt_en && m_cnt <= BB) cause_n = 1;
            else if (beat && cfg_short_en && !cfg_dir_in && buf_rd_last && buf_rd_short) cause_n = 2;
         end
         term = (cause_n >= 0);
         if (rise) begin
            m_active = 1; m_done = 0; m_irq = 0; m_cnt = cfg_count; m_gap = 0; m_bcnt = 0;
         end else begin
            m_gap = beat && lastb;
            if (beat) m_bcnt = lastb ? 0 : m_bcnt + 1;
            if (m_active && !cfg_en) begin
               m_active = 0; m_done = 1; m_irq = 0; m_cause = 3;
            end else if (term) begin
               m_active = 0; m_done = 1; m_irq = 1; m_cause = cause_n;
            end else begin
               m_irq = 0;
               if (beat) m_cnt = (m_cnt >= BB) ? m_cnt - BB : 0;
            end
         end
         m_en_q = cfg_en;
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic restart_en();
      cfg_en = 0; step(); cfg_en = 1; step();
   endtask

   // one-cycle pulse of the given pin set
   task automatic pulse(logic ack, logic rd, logic wr);
      dma_ack = ack ? cfg_ack_pol : !cfg_ack_pol;
      dma_rd_stb = rd; dma_wr_stb = wr;
      step();
      dma_ack = !cfg_ack_pol; dma_rd_stb = 0; dma_wr_stb = 0;
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int p0;
      repeat (3) @(posedge clk); #1;
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset req", dma_req, 0);
      chk("R1 reset done", xfer_done, 0);
      chk("R1 reset irq", xfer_irq, 0);
      step();

      // counter termination, strobe-qualified OUT, single cycle
      cfg_dir_in = 0; cfg_ack_only = 0; cfg_burst = 0; cfg_cnt_en = 1; cfg_count = 6;
      restart_en();
      p0 = rd_ptr;
      pulse(1, 0, 1);                         // write strobe on OUT: ignored
      chk("R3 wrong strobe ignored", rd_ptr, p0);
      pulse(0, 1, 0);                         // no ack: ignored
      chk("R3 strobe without ack", rd_ptr, p0);
      repeat (3) pulse(1, 1, 0);
      chk("R12 pops", rd_ptr, p0 + 3);
      chk("R7 count done", xfer_done, 1);
      chk("R7 count cause", xfer_cause, 1);
      chk("R7 req held", dma_req, 0);
      pulse(1, 1, 0);
      chk("R13 ignored after done", rd_ptr, p0 + 3);

      // IN, acknowledge as strobe, burst, external end
      cfg_dir_in = 1; cfg_ack_only = 1; cfg_burst = 1; cfg_cnt_en = 0;
      pushed.delete();
      restart_en();
      pulse(0, 1, 1);
      chk("R4 strobes ignored", pushed.size(), 0);
      dma_ack = 1;
      for (int i = 0; i < 3; i++) begin dma_wdata = DW'(i); step(); end
      dma_ack = 0;
      @(negedge clk);
      chk("R6 req kept in burst", dma_req, 1);
      step();
      dma_ack = 1;
      for (int i = 3; i < 8; i++) begin dma_wdata = DW'(i); step(); end
      dma_ack = 0;
      @(negedge clk);
      chk("R6 gap after burst", dma_req, 0);
      @(negedge clk);
      chk("R6 req back", dma_req, 1);
      chk("R4 push count", pushed.size(), 8);
      for (int i = 0; i < 8; i++) chk("R12 pushed data", pushed[i], i);
      step();
      dma_eot = 1;
      @(negedge clk);
      chk("R9 commit pulse", buf_commit, 1);
      step(); dma_eot = 0;
      @(negedge clk);
      chk("R9 end cause", xfer_cause, 0);
      chk("R9 done", xfer_done, 1);
      step();

      // OUT, inverted polarities, external end flushes
      cfg_dir_in = 0; cfg_ack_only = 0; cfg_burst = 0;
      cfg_req_pol = 0; cfg_ack_pol = 0; cfg_eot_pol = 0;
      dma_ack = 1; dma_eot = 1;
      restart_en();
      @(negedge clk);
      chk("R2 active-low request", dma_req, 0);
      step();
      p0 = rd_ptr;
      repeat (2) pulse(1, 1, 0);
      chk("R2 low ack beats", rd_ptr, p0 + 2);
      dma_eot = 0;
      @(negedge clk);
      chk("R8 flush pulse", buf_flush, 1);
      step(); dma_eot = 1;
      @(negedge clk);
      chk("R8 end cause", xfer_cause, 0);
      step();
      cfg_req_pol = 1; cfg_ack_pol = 1; cfg_eot_pol = 1;
      dma_ack = 0; dma_eot = 0;
      step();

      // short packet on OUT
      cfg_ack_only = 1; cfg_short_en = 1; short_on = 1;
      restart_en();
      p0 = rd_ptr; last_idx = rd_ptr + 2;
      repeat (3) pulse(1, 0, 0);
      chk("R10 short moved", rd_ptr, p0 + 3);
      chk("R10 short cause", xfer_cause, 2);
      chk("R10 short done", xfer_done, 1);
      short_on = 0; cfg_short_en = 0;

      // disable mid-transfer
      cfg_ack_only = 0;
      restart_en();
      pulse(1, 1, 0);
      cfg_en = 0;
      @(negedge clk);
      chk("R11 not yet done", xfer_done, 0);
      step();
      chk("R11 disable cause", xfer_cause, 3);
      chk("R11 no irq", xfer_irq, 0);
      repeat (4) step();

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule